// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a two-wire bus slave that fronts an 8,192-entry byte store built as an inferred register array. A fast system clock oversamples the bus clock and data lines. The block recognises start and stop conditions and compares the incoming device address against a fixed 4-bit tag plus three strap pins, so up to eight of these blocks can share one bus. It then takes a 16-bit word address sent as two bytes and performs single or sequential byte writes and reads.

The data line is modelled as an open-drain pair. `sda_i` is the resolved bus level and `sda_oe_o` pulls the line low when it is set. The block never drives the bus clock. Stored bytes take effect while the byte is still on the bus, so there is no internal busy period. A new device address is acknowledged as soon as the previous transaction has stopped.

Top module: `serial_byte_mem`

## Requirements
- R1: After reset the block does not pull the data line low (`sda_oe_o` = 0) and ignores the bus until a start condition is seen.
- R2: The block acknowledges the first byte after a start only when its upper seven bits equal binary 1010 followed by `strap_i[2:0]`, MSB first. Bit 0 is the direction: 1 means read. On any mismatch it leaves the line released for every remaining clock until the next start or stop.
- R3: In a write, the two bytes after the device address form the word address, high byte first. Each later data byte is stored at the pointer and acknowledged, and the pointer then advances by one.
- R4: Only the low 13 bits of the 16-bit word address choose a location. The top three bits have no effect.
- R5: The pointer wraps from 0x1FFF to 0x0000 on both writes and reads.
- R6: A repeated start followed by a read-direction device address returns bytes starting at the pointer set by the preceding address phase. Each byte is sent MSB first.
- R7: During a read, an acknowledge from the master on the ninth clock makes the block send the next byte. A not-acknowledge ends the transfer, and the line stays released.
- R8: A start and device address sent right after a write's stop is acknowledged at once, with no ready polling.
- R9: `sda_oe_o` changes only while the bus clock is low.
- R10: A stop received in the middle of a data byte abandons that byte, and no location is written.
- R11: A read that starts without an address phase continues from the pointer left by the previous access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Resolved bus data level |
| strap_i | input | 3 | Low three bits of the device address |
| sda_oe_o | output | 1 | When high, pulls the data line low |

## Verification
The hardest cases to reach from the ports are the ones where the pointer crosses the top of the array, and where a stop arrives part-way through a data byte. Both leave nothing visible until a later read. The bench writes across 0x1FFF, cuts a data byte off after four bits, and then reads back through the normal address-and-repeated-start sequence, which exposes the pointer and the array contents. A bench-side model of the array and pointer predicts the level of `sda_oe_o` on every system clock inside each bit window, so a wrong ack, a wrong data bit or a late release is caught on the exact bit where it occurs.

// File: rtl/smem_pkg.sv
package smem_pkg;
    localparam logic [3:0] DEV_TAG = 4'b1010;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_AHI,
        S_AHI_ACK,
        S_ALO,
        S_ALO_ACK,
        S_WR,
        S_WR_ACK,
        S_RD,
        S_RD_ACK
    } bus_st_e;
endpackage

// File: rtl/smem_sync.sv
module smem_sync #(
    parameter int WIDTH = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] lvl_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
        logic [WIDTH-1:0] s3;
    } sync_t;

    sync_t d, q;

    always_comb begin
        d.s1 = din_i;
        d.s2 = q.s1;
        d.s3 = q.s2;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{s1: '1, s2: '1, s3: '1};
        end else begin
            q <= d;
        end
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_edge
        assign lvl_o[g]  = q.s2[g];
        assign rise_o[g] = q.s2[g] & ~q.s3[g];
        assign fall_o[g] = ~q.s2[g] & q.s3[g];
    end
endmodule

// File: rtl/smem_array.sv
module smem_array #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) begin
            cells_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells_q[addr_i];
endmodule

// File: rtl/smem_bus.sv
module smem_bus
    import smem_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int STRAP_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               scl_lv_i,
    input  logic               scl_rise_i,
    input  logic               scl_fall_i,
    input  logic               sda_lv_i,
    input  logic               sda_rise_i,
    input  logic               sda_fall_i,
    input  logic [STRAP_W-1:0] strap_i,
    input  logic [7:0]         rd_data_i,
    output logic               mem_we_o,
    output logic [ADDR_W-1:0]  mem_addr_o,
    output logic [7:0]         mem_wdata_o,
    output logic               sda_oe_o
);
    localparam int            FULL_W  = 16;
    localparam logic [3:0]    BYTE_END = 4'd8;

    typedef struct packed {
        bus_st_e             st;
        logic [3:0]          cnt;
        logic [7:0]          sr;
        logic [7:0]          tx;
        logic [7:0]          hi;
        logic [ADDR_W-1:0]   ptr;
        logic                rnw;
        logic                more;
        logic                oe;
    } bus_t;

    bus_t d, q;
    logic start_det, stop_det, recv_st, ack_st;
    logic [FULL_W-1:0] full_addr;
    logic              we;

    assign start_det = scl_lv_i & sda_fall_i;
    assign stop_det  = scl_lv_i & sda_rise_i;
    assign recv_st   = (q.st == S_DEV) || (q.st == S_AHI) ||
                       (q.st == S_ALO) || (q.st == S_WR);
    assign ack_st    = (q.st == S_DEV_ACK) || (q.st == S_AHI_ACK) ||
                       (q.st == S_ALO_ACK) || (q.st == S_WR_ACK);
    assign full_addr = {q.hi, q.sr};

    always_comb begin
        d  = q;
        we = 1'b0;
        if (start_det) begin
            d.st  = S_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_det) begin
            d.st  = S_IDLE;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (recv_st) begin
            if (scl_rise_i && q.cnt != BYTE_END) begin
                d.sr  = {q.sr[6:0], sda_lv_i};
                d.cnt = q.cnt + 4'd1;
            end else if (scl_fall_i && q.cnt == BYTE_END) begin
                d.cnt = '0;
                unique case (q.st)
                    S_DEV: begin
                        if (q.sr[7:1] == {DEV_TAG, strap_i}) begin
                            d.oe  = 1'b1;
                            d.rnw = q.sr[0];
                            d.st  = S_DEV_ACK;
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                    S_AHI: begin
                        d.hi = q.sr;
                        d.oe = 1'b1;
                        d.st = S_AHI_ACK;
                    end
                    S_ALO: begin
                        d.ptr = full_addr[ADDR_W-1:0];
                        d.oe  = 1'b1;
                        d.st  = S_ALO_ACK;
                    end
                    default: begin
                        we    = 1'b1;
                        d.ptr = q.ptr + 1'b1;
                        d.oe  = 1'b1;
                        d.st  = S_WR_ACK;
                    end
                endcase
            end
        end else if (ack_st) begin
            if (scl_fall_i) begin
                d.oe  = 1'b0;
                d.cnt = '0;
                unique case (q.st)
                    S_DEV_ACK: begin
                        if (q.rnw) begin
                            d.tx = rd_data_i;
                            d.oe = ~rd_data_i[7];
                            d.st = S_RD;
                        end else begin
                            d.st = S_AHI;
                        end
                    end
                    S_AHI_ACK: d.st = S_ALO;
                    default:   d.st = S_WR;
                endcase
            end
        end else if (q.st == S_RD) begin
            if (scl_rise_i) begin
                d.cnt = q.cnt + 4'd1;
            end else if (scl_fall_i) begin
                if (q.cnt == BYTE_END) begin
                    d.oe  = 1'b0;
                    d.cnt = '0;
                    d.ptr = q.ptr + 1'b1;
                    d.st  = S_RD_ACK;
                end else begin
                    d.tx = {q.tx[6:0], 1'b0};
                    d.oe = ~q.tx[6];
                end
            end
        end else if (q.st == S_RD_ACK) begin
            if (scl_rise_i) begin
                d.more = ~sda_lv_i;
            end else if (scl_fall_i) begin
                if (q.more) begin
                    d.tx = rd_data_i;
                    d.oe = ~rd_data_i[7];
                    d.st = S_RD;
                end else begin
                    d.st = S_IDLE;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{st: S_IDLE, cnt: '0, sr: '0, tx: '0, hi: '0,
                   ptr: '0, rnw: 1'b0, more: 1'b0, oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign mem_we_o    = we;
    assign mem_addr_o  = q.ptr;
    assign mem_wdata_o = q.sr;
    assign sda_oe_o    = q.oe;

    // R9: the pull-down only toggles while the sampled bus clock is low
    assert_oe_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.oe != $past(q.oe)) |-> !scl_lv_i);

    // R2: the line is pulled low only in an ack slot or while sending data
    assert_drive_slots_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        q.oe |-> (ack_st || q.st == S_RD));

    // R3: every stored byte is followed by an acknowledge
    assert_store_acked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        mem_we_o |=> (q.oe && q.st == S_WR_ACK));

    // R5: advancing past the top location lands on zero
    assert_ptr_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(q.ptr) == '1 && q.ptr != $past(q.ptr) && $past(q.st) != S_ALO)
        |-> q.ptr == '0);

    // R10: a stop returns the block to idle with the line released
    assert_stop_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_det && !start_det) |=> (q.st == S_IDLE && !q.oe && !mem_we_o));

    // R1: idle never pulls the line
    assert_idle_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.st == S_IDLE) |-> !q.oe);
endmodule

// File: rtl/serial_byte_mem.sv
module serial_byte_mem #(
    parameter int ADDR_W  = 13,
    parameter int STRAP_W = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] strap_i,
    output logic               sda_oe_o
);
    localparam int LINES = 2;
    localparam int SCL_B = 1;
    localparam int SDA_B = 0;

    logic [LINES-1:0]  lvl, rise, fall;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata, mem_rdata;

    smem_sync #(.WIDTH(LINES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .din_i  ({scl_i, sda_i}),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    smem_bus #(.ADDR_W(ADDR_W), .STRAP_W(STRAP_W)) u_bus (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .scl_lv_i    (lvl[SCL_B]),
        .scl_rise_i  (rise[SCL_B]),
        .scl_fall_i  (fall[SCL_B]),
        .sda_lv_i    (lvl[SDA_B]),
        .sda_rise_i  (rise[SDA_B]),
        .sda_fall_i  (fall[SDA_B]),
        .strap_i     (strap_i),
        .rd_data_i   (mem_rdata),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata),
        .sda_oe_o    (sda_oe_o)
    );

    smem_array #(.ADDR_W(ADDR_W), .DATA_W(8)) u_array (
        .clk_i   (clk_i),
        .we_i    (mem_we),
        .addr_i  (mem_addr),
        .wdata_i (mem_wdata),
        .rdata_o (mem_rdata)
    );
endmodule

// File: tb/sim_serial_byte_mem.sv
module sim_serial_byte_mem;
    localparam int Q     = 8;
    localparam int DEPTH = 8192;

    typedef logic [7:0] bytes_t[$];

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] strap = 3'b101;
    logic       sda_oe;
    logic       sda_bus;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    serial_byte_mem u0 (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_bus),
        .strap_i  (strap),
        .sda_oe_o (sda_oe)
    );

    int    checks = 0;
    int    errors = 0;
    logic  chk_en = 1'b0;
    logic  exp_oe = 1'b0;
    string chk_req = "R9";
    logic [7:0] model [DEPTH];
    int    mptr = 0;
    bit    done = 1'b0;

    // per-clock comparison of the pull-down against the model's prediction
    always @(negedge clk) begin
        if (chk_en) begin
            checks++;
            if (sda_oe !== exp_oe) begin
                errors++;
                $display("FAIL %s: sda_oe=%b expected %b at %0t", chk_req, sda_oe, exp_oe, $time);
            end
        end
    end

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bit_xfer(input logic drv, input logic eo, input string req, output logic seen);
        sda_m = drv;
        clocks(Q);
        exp_oe  = eo;
        chk_req = req;
        chk_en  = 1'b1;
        scl = 1'b1;
        clocks(Q);
        seen = sda_bus;
        clocks(Q);
        chk_en = 1'b0;
        scl = 1'b0;
        clocks(Q);
    endtask

    task automatic start_cond();
        sda_m = 1'b1;
        clocks(Q);
        scl = 1'b1;
        clocks(Q);
        sda_m = 1'b0;
        clocks(Q);
        scl = 1'b0;
        clocks(Q);
    endtask

    task automatic stop_cond();
        sda_m = 1'b0;
        clocks(Q);
        scl = 1'b1;
        clocks(Q);
        sda_m = 1'b1;
        clocks(2 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack_exp, input string req);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(b[i], 1'b0, req, s);
        bit_xfer(1'b1, ack_exp, req, s);
        check_val(req, int'(s), int'(!ack_exp));
    endtask

    task automatic recv_byte(input logic [7:0] exp, input logic m_ack, input string req);
        logic       s;
        logic [7:0] got;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, ~exp[i], req, s);
            got[i] = s;
        end
        check_val(req, int'(got), int'(exp));
        bit_xfer(~m_ack, 1'b0, req, s);
    endtask

    function automatic logic [7:0] dev(input logic rnw);
        return {4'b1010, strap, rnw};
    endfunction

    task automatic addr_phase(input logic [15:0] a, input string req);
        start_cond();
        send_byte(dev(1'b0), 1'b1, "R8");
        send_byte(a[15:8], 1'b1, req);
        send_byte(a[7:0], 1'b1, req);
        mptr = int'(a[12:0]);
    endtask

    task automatic write_seq(input logic [15:0] a, input bytes_t data, input string req);
        addr_phase(a, req);
        foreach (data[k]) begin
            send_byte(data[k], 1'b1, req);
            model[mptr] = data[k];
            mptr = (mptr + 1) % DEPTH;
        end
        stop_cond();
    endtask

    task automatic read_body(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            recv_byte(model[mptr], (k != n - 1), req);
            mptr = (mptr + 1) % DEPTH;
        end
    endtask

    task automatic read_at(input logic [15:0] a, input int n, input string req);
        addr_phase(a, req);
        start_cond();
        send_byte(dev(1'b1), 1'b1, req);
        read_body(n, req);
        stop_cond();
    endtask

    initial begin
        logic s;
        clocks(5);
        // R1: released during and after reset
        check_val("R1", int'(sda_oe), 0);
        rst_n = 1'b1;
        clocks(20);
        check_val("R1", int'(sda_oe), 0);

        // R3 / R6 / R8: sequential write then repeated-start read
        write_seq(16'h0123, '{8'hA5, 8'h3C, 8'hFF, 8'h00, 8'h5A, 8'h81}, "R3");
        read_at(16'h0123, 4, "R6");

        // R11: read with no address phase continues at 0x0127
        start_cond();
        send_byte(dev(1'b1), 1'b1, "R11");
        read_body(2, "R11");
        stop_cond();

        // R4: top three address bits ignored
        write_seq(16'hE040, '{8'h77, 8'h88}, "R4");
        read_at(16'h0040, 2, "R4");
        read_at(16'h6040, 1, "R4");

        // R5: write and read across the top of the array
        write_seq(16'h1FFE, '{8'hB0, 8'hC1, 8'hD2}, "R5");
        read_at(16'h1FFE, 3, "R5");
        read_at(16'h0000, 1, "R5");

        // R7: after a NACK the block stays released for further clocks
        read_at(16'h0124, 1, "R7");
        start_cond();
        send_byte(dev(1'b1), 1'b1, "R7");
        recv_byte(model[16'h0125], 1'b0, "R7");
        bit_xfer(1'b1, 1'b0, "R7", s);
        check_val("R7", int'(s), 1);
        stop_cond();

        // R2: wrong strap bits and wrong tag are not acknowledged
        start_cond();
        send_byte({4'b1010, ~strap, 1'b0}, 1'b0, "R2");
        send_byte(8'h00, 1'b0, "R2");
        stop_cond();
        start_cond();
        send_byte({4'b1011, strap, 1'b1}, 1'b0, "R2");
        send_byte(8'h00, 1'b0, "R2");
        stop_cond();
        strap = 3'b010;
        clocks(4);
        write_seq(16'h0300, '{8'h4E}, "R2");
        read_at(16'h0300, 1, "R2");

        // R10: stop halfway through a data byte leaves the location intact
        write_seq(16'h0200, '{8'h11}, "R10");
        addr_phase(16'h0200, "R10");
        for (int i = 0; i < 4; i++) bit_xfer(1'b0, 1'b0, "R10", s);
        stop_cond();
        read_at(16'h0200, 1, "R10");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clocks(190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, got hang expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule